// File: doc/BRIEF.md
# Digital Potentiometer Command Slave on a Two-Wire Bus

This block is the serial front end of a digitally controlled resistor. It oversamples the two-wire bus clock and data lines against a local system clock, finds start, repeated start and stop conditions, and answers a 7-bit bus address. Two strap pins set part of that address. After an addressed write, a single instruction byte selects one of several commands. The commands set the wiper register, copy the wiper to or from a nonvolatile shadow register, switch a software write lock, or choose which register a later read returns.

The nonvolatile shadow register is modelled as an ordinary flop bank that is written in one cycle. The block drives the data line only as an open-drain pull-down enable. The surrounding pad logic turns that enable into a low level on the bus. The wiper, shadow and lock values are brought out as plain outputs for the resistor array.

Top module: `dpot_i2c_slave`

## Requirements
- R1: A start is seen when SDA falls while SCL is high, and a stop when SDA rises while SCL is high. Bits clocked on the bus after a stop and before the next start are ignored. They get no acknowledge and change no register.
- R2: The first byte after a start is a 7-bit address, MSB first, followed by a direction bit (1 = read, 0 = write). When the address matches, the block pulls SDA low through the ninth clock of that byte and of every later byte it accepts in a write.
- R3: The address is `0011` followed by `1`, then pin bit 1, then pin bit 0. The two select pins are captured once, on the first clock after reset is released, and later pin changes have no effect. On a mismatch the block never pulls SDA until the next start.
- R4: Instruction code `001` is a wiper write. Every data byte that follows, up to the stop, loads the wiper register.
- R5: The instruction is the second byte of a write, and its bits [7:5] carry the command: 000 no-op, 001 wiper write, 010 store, 011 restore, 100 lock, 101 read wiper, 110 read shadow. An instruction whose bits [4:0] are not all zero is acknowledged and then treated as a no-op.
- R6: Store (`010`) copies the wiper register into the shadow register, and restore (`011`) copies the shadow register into the wiper register. Each takes effect when the instruction byte is accepted, with no data byte.
- R7: For lock (`100`), bit 0 of each data byte turns the lock on (1) or off (0), and the data byte is not stored. While the lock is on, wiper writes and stores still get an acknowledge but do not change any register. Restore still works.
- R8: A read is an addressed write of an instruction byte, then a repeated start, then the address with the direction bit set. The block then sends the shadow register if the last accepted instruction was `110`, and the wiper register otherwise, MSB first. It changes its SDA drive only while SCL is low.
- R9: After a read byte, an acknowledge from the master makes the block send the register again. A not-acknowledge makes it release SDA and wait for the next start.
- R10: After reset the wiper and shadow registers both hold the parameter value (default 0x80), the lock is off, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_sel_i | input | 2 | Address strap pins, captured after reset |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper_o | output | 8 | Wiper register value |
| nvm_o | output | 8 | Nonvolatile shadow register value |
| lock_o | output | 1 | Software write lock state |

## Verification
Wiper writes are driven from a table of data bytes: all zeros, all ones, alternating bits, and single set bits at each end of the byte. Any stuck, swapped or shifted data bit therefore shows up as a wrong wiper value. Directed sequences then cover the following:
- Store, restore, and the lock in both directions. The lock is applied so that each ignored wiper write or store would leave a visibly different value if it took effect.
- Reads of both registers across a repeated start, with the master acknowledging and then not acknowledging.
- A wrong address, clocking without a start, and strap pins changed after reset. These separate correct address decoding from simple acceptance of every byte.

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
  parameter logic [4:0] ADDR_HI    = 5'b00111,
  parameter logic [7:0] WIPER_INIT = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  output logic       sda_pull_o,
  output logic [7:0] wiper_o,
  output logic [7:0] nvm_o,
  output logic       lock_o
);
  localparam logic [2:0] CMD_NOP = 3'b000, CMD_WR = 3'b001, CMD_STORE = 3'b010,
                         CMD_RESTORE = 3'b011, CMD_LOCK = 3'b100, CMD_RDNVM = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_INSTR, S_DATA, S_READ} st_t;

  logic [2:0] scl_q, sda_q;
  logic [1:0] sel_q;
  logic       cap_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, wiper_q, nvm_q;
  logic [2:0] cmd_q;
  logic       lock_q, mack_q, pull_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

  logic [6:0] my_addr;
  logic [7:0] rd_val;
  logic       instr_ok;
  assign my_addr  = {ADDR_HI, sel_q};
  assign rd_val   = (cmd_q == CMD_RDNVM) ? nvm_q : wiper_q;
  assign instr_ok = (shreg[4:0] == 5'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q   <= 2'b00;
      cap_q   <= 1'b0;
      st      <= S_IDLE;
      bitcnt  <= 4'd0;
      shreg   <= 8'h00;
      wiper_q <= WIPER_INIT;
      nvm_q   <= WIPER_INIT;
      cmd_q   <= CMD_NOP;
      lock_q  <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      if (!cap_q) begin
        sel_q <= addr_sel_i;
        cap_q <= 1'b1;
      end
      if (start_det) begin
        st     <= S_ADDR;
        bitcnt <= 4'd0;
        pull_q <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        pull_q <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt == 4'd8)    mack_q <= ~sda_q[1];
          else if (st != S_READ) shreg  <= {shreg[6:0], sda_q[1]};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            pull_q <= 1'b1;
            case (st)
              S_ADDR:
                if (shreg[7:1] == my_addr) st <= shreg[0] ? S_READ : S_INSTR;
                else begin
                  pull_q <= 1'b0;
                  st     <= S_IDLE;
                end
              S_INSTR: begin
                st    <= S_DATA;
                cmd_q <= instr_ok ? shreg[7:5] : CMD_NOP;
                if (instr_ok && shreg[7:5] == CMD_STORE && !lock_q) nvm_q <= wiper_q;
                if (instr_ok && shreg[7:5] == CMD_RESTORE) wiper_q <= nvm_q;
              end
              S_DATA:
                if (cmd_q == CMD_WR && !lock_q) wiper_q <= shreg;
                else if (cmd_q == CMD_LOCK)     lock_q  <= shreg[0];
              S_READ: pull_q <= 1'b0;
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= 4'd0;
            pull_q <= 1'b0;
            if (st == S_READ) begin
              if (mack_q) begin
                shreg  <= rd_val;
                pull_q <= ~rd_val[7];
              end else st <= S_IDLE;
            end
          end else if (st == S_READ) begin
            pull_q <= ~shreg[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end

  assign sda_pull_o = pull_q;
  assign wiper_o    = wiper_q;
  assign nvm_o      = nvm_q;
  assign lock_o     = lock_q;

  // R8
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q[1] && $past(scl_q[1])) |-> $stable(pull_q));
  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !pull_q);
  // R3
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q && $past(cap_q)) |-> $stable(sel_q));
  // R7
  lock_nvm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> $stable(nvm_q));
  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);
endmodule

// File: tb/dpot_i2c_slave_tb.sv
module dpot_i2c_slave_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic [1:0] pins = 2'b10;
  logic sda_pull, lock;
  logic [7:0] wiper, nvm;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_pull;

  dpot_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_sel_i(pins),
    .sda_pull_o(sda_pull), .wiper_o(wiper), .nvm_o(nvm), .lock_o(lock)
  );

  localparam int H = 16;
  localparam logic [7:0] AW = 8'h3C, AR = 8'h3D;
  localparam logic [15:0] VEC [8] = '{16'h0000, 16'hFFFF, 16'h5555, 16'hAAAA,
                                      16'h0101, 16'h8080, 16'h7F7F, 16'hC3C3};
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    m_sda = 1; tick(H); scl = 1; tick(H); m_sda = 0; tick(H); scl = 0; tick(2);
  endtask

  task automatic stop();
    m_sda = 0; tick(H); scl = 1; tick(H); m_sda = 1; tick(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); scl = 1; tick(H); scl = 0; tick(2);
    end
    m_sda = 1; tick(H); scl = 1; tick(H/2); ack = ~sda_bus; tick(H/2); scl = 0; tick(2);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1; tick(H/2); b[i] = sda_bus; tick(H/2); scl = 0; tick(2);
    end
    m_sda = mack ? 1'b0 : 1'b1; tick(H); scl = 1; tick(H); scl = 0; tick(2); m_sda = 1;
  endtask

  task automatic cmd2(input logic [7:0] ins, input string req);
    bit a;
    start(); wbyte(AW, a); chk(a, req, a, 1); wbyte(ins, a); chk(a, req, a, 1); stop();
  endtask

  task automatic cmd3(input logic [7:0] ins, input logic [7:0] d, input string req);
    bit a;
    start(); wbyte(AW, a); chk(a, req, a, 1); wbyte(ins, a); chk(a, req, a, 1);
    wbyte(d, a); chk(a, req, a, 1); stop();
  endtask

  task automatic rd(input logic [7:0] ins, output logic [7:0] v);
    bit a;
    start(); wbyte(AW, a); chk(a, "R8 addr ack", a, 1); wbyte(ins, a);
    start(); wbyte(AR, a); chk(a, "R8 read addr ack", a, 1);
    rbyte(1'b0, v); stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] v;
    tick(5); rst_n = 1; tick(5);
    chk(wiper == 8'h80, "R10 wiper reset", wiper, 8'h80);
    chk(nvm == 8'h80, "R10 shadow reset", nvm, 8'h80);
    chk(lock == 0, "R10 lock reset", lock, 0);
    chk(sda_pull == 0, "R10 sda released", sda_pull, 0);
    pins = 2'b01;

    foreach (VEC[i]) begin
      cmd3(8'h20, VEC[i][15:8], "R2 ack");
      chk(wiper == VEC[i][7:0], "R4 wiper write", wiper, VEC[i][7:0]);
    end

    start(); wbyte(AW, a); wbyte(8'h20, a);
    wbyte(8'h12, a); chk(wiper == 8'h12, "R4 repeat 1", wiper, 8'h12);
    wbyte(8'h34, a); chk(wiper == 8'h34, "R4 repeat 2", wiper, 8'h34);
    wbyte(8'h56, a); chk(a && wiper == 8'h56, "R4 repeat 3", wiper, 8'h56);
    stop();

    start(); wbyte(8'h40, a); chk(!a, "R3 mismatch no ack", a, 0);
    wbyte(8'h20, a); chk(!a, "R3 mismatch idle", a, 0);
    wbyte(8'h99, a); stop();
    chk(wiper == 8'h56, "R3 mismatch no write", wiper, 8'h56);

    start(); wbyte(8'h3A, a); stop();
    chk(!a, "R3 late pin change ignored", a, 0);

    scl = 0; tick(H);
    wbyte(AW, a); chk(!a, "R1 no start no ack", a, 0);
    wbyte(8'h20, a); wbyte(8'h77, a);
    m_sda = 1; tick(H); scl = 1; tick(H);
    chk(wiper == 8'h56, "R1 no start no write", wiper, 8'h56);

    cmd3(8'h20, 8'h3C, "R4 ack");
    cmd2(8'h40, "R6 store ack");
    chk(nvm == 8'h3C, "R6 store", nvm, 8'h3C);
    cmd3(8'h20, 8'h11, "R4 ack");
    cmd2(8'h60, "R6 restore ack");
    chk(wiper == 8'h3C, "R6 restore", wiper, 8'h3C);

    cmd3(8'h21, 8'h55, "R5 bad instr ack");
    chk(wiper == 8'h3C, "R5 bad instr ignored", wiper, 8'h3C);

    cmd3(8'h20, 8'h44, "R4 ack");
    cmd3(8'h80, 8'h01, "R7 lock ack");
    chk(lock == 1, "R7 lock on", lock, 1);
    cmd3(8'h20, 8'h99, "R7 locked write ack");
    chk(wiper == 8'h44, "R7 locked write ignored", wiper, 8'h44);
    cmd2(8'h40, "R7 locked store ack");
    chk(nvm == 8'h3C, "R7 locked store ignored", nvm, 8'h3C);
    cmd3(8'h80, 8'hFE, "R7 unlock ack");
    chk(lock == 0, "R7 lock off by bit 0", lock, 0);
    chk(wiper == 8'h44, "R7 lock data not stored", wiper, 8'h44);
    cmd3(8'h20, 8'h99, "R4 ack");
    chk(wiper == 8'h99, "R7 unlocked write", wiper, 8'h99);

    rd(8'hA0, v); chk(v == 8'h99, "R8 read wiper", v, 8'h99);
    rd(8'hC0, v); chk(v == 8'h3C, "R8 read shadow", v, 8'h3C);

    start(); wbyte(AW, a); wbyte(8'hA0, a);
    start(); wbyte(AR, a);
    rbyte(1'b1, v); chk(v == 8'h99, "R9 repeated read 1", v, 8'h99);
    rbyte(1'b0, v); chk(v == 8'h99, "R9 repeated read 2", v, 8'h99);
    tick(4); chk(sda_pull == 0, "R9 release after nack", sda_pull, 0);
    stop();
    cmd3(8'h20, 8'h5A, "R9 bus usable");
    chk(wiper == 8'h5A, "R9 write after read", wiper, 8'h5A);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule